// File: doc/BRIEF.md
# Transactional L1 Data Cache with Conflict Tracking

This block models a small set-associative L1 data cache for one core that runs best-effort hardware transactions. Each line carries two membership flags, one for the transaction's read set and one for its write set. Stores issued inside a transaction stay in the line as speculative data and reach the rest of the system only when the transaction commits. On an abort the write set is thrown away and both sets are emptied in the same cycle.

Coherence snoops from other agents are compared with the membership flags. A remote write that touches either set, or a remote read that touches the write set, ends the transaction. This holds whether or not the remote access was itself transactional. The transaction also ends when the core performs an I/O operation, issues an explicit abort, or needs a new line in a set whose ways all belong to the transaction. A code on the status output records why the transaction ended. Line refill is modelled by a fill word that the environment presents with each access; refill from memory, the directory and the software fallback path all sit outside the block.

Each line holds one data word. A core operation and a snoop can arrive in the same cycle. The snoop is ordered first, and a snoop that ends the transaction cancels the core operation of that cycle.

Top module: `tcache_top`

## Requirements
- R1: After reset the block is outside a transaction, the reason code is 0, no load or snoop response is flagged, and every line is invalid, so a snoop finds no hit.
- R2: Outside a transaction, a load (opcode 1) answers in the next cycle. A hit returns the line's data. A miss returns `fillData` and allocates the line. A store (opcode 2) allocates on a miss and updates the line.
- R3: Inside a transaction, loads join the read set and stores join the write set. A later load by the same core returns its own speculative store data.
- R4: Inside a transaction, a snoop write that hits a read-set or write-set line, or a snoop read that hits a write-set line, aborts with reason 1 (conflict). A snoop read of a line that is only in the read set does not abort, and it receives the line's data.
- R5: A snoop to a line that is in neither set, or that is not cached, leaves the transaction running with reason 0.
- R6: A commit (opcode 4) empties both sets and leaves with reason 0. Written lines become visible: a later snoop read hits them, returns the stored data and reports them dirty. Before the commit, a snoop read of a speculatively written line reports no hit.
- R7: On an abort, every write-set line is invalidated, so a later load returns `fillData`. The read set is emptied, so in a new transaction a snoop write to a previously read line does not conflict.
- R8: A transactional miss into a set whose ways are all in a set, while some other line in the cache is outside both sets, aborts with reason 3 (associativity).
- R9: A transactional miss when every line of the cache is in a set aborts with reason 2 (capacity).
- R10: An I/O operation (opcode 6) inside a transaction aborts with reason 4. Outside a transaction it has no effect.
- R11: An explicit abort (opcode 5) inside a transaction aborts with reason 5. Commit and abort opcodes issued outside a transaction have no effect.
- R12: The reason code holds its value until the next begin (opcode 3), which clears it to 0 and enters a transaction.
- R13: When a snoop conflict falls in the same cycle as a core commit or load, the abort wins. The commit does not publish data, and the load gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coreOp | input | 3 | Core operation: 0 idle, 1 load, 2 store, 3 begin, 4 commit, 5 abort, 6 I/O |
| coreAddr | input | ADDR_W | Word address of a load or store; low bits select the set |
| coreWData | input | DATA_W | Store data |
| fillData | input | DATA_W | Word that memory would return on a load miss |
| snpValid | input | 1 | A snoop from another agent is present |
| snpWrite | input | 1 | Snoop kind: 1 write or ownership request, 0 read |
| snpAddr | input | ADDR_W | Snoop word address |
| loadValid | output | 1 | Load result valid, one cycle after the load |
| loadData | output | DATA_W | Load result |
| snpRespValid | output | 1 | Snoop answer valid, one cycle after the snoop |
| snpRespHit | output | 1 | Snoop found a visible, non-speculative copy |
| snpRespDirty | output | 1 | That copy was modified locally |
| snpRespData | output | DATA_W | Data of that copy |
| inTx | output | 1 | A transaction is running |
| abortReason | output | 3 | 0 none, 1 conflict, 2 capacity, 3 associativity, 4 I/O, 5 explicit |

## Verification
A snoop and a core operation can land in the same cycle. The case that matters is a conflicting snoop write that arrives together with the commit of the transaction it breaks. The bench drives both on one edge. It then expects reason 1, no transaction, and a later load that returns the fill word rather than the speculative value. A second case pairs a conflicting snoop with a load, and the bench expects no load response. As controls, the same commit paired with a snoop to an unrelated address must publish the data, and a read snoop of a line that is only in the read set must not abort.

// File: rtl/tcache_pkg.sv
package tcache_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_LOAD   = 3'd1,
    OP_STORE  = 3'd2,
    OP_BEGIN  = 3'd3,
    OP_COMMIT = 3'd4,
    OP_ABORT  = 3'd5,
    OP_IO     = 3'd6
  } coreOp_e;

  typedef enum logic [2:0] {
    RSN_NONE     = 3'd0,
    RSN_CONFLICT = 3'd1,
    RSN_CAPACITY = 3'd2,
    RSN_ASSOC    = 3'd3,
    RSN_IO       = 3'd4,
    RSN_EXPLICIT = 3'd5
  } abortRsn_e;

  // strobes from control to datapath
  typedef struct packed {
    logic doLoad;
    logic doStore;
    logic txMark;
    logic commitAll;
    logic abortAll;
  } ctrlStrb_t;

  // lookup status from datapath to control
  typedef struct packed {
    logic snpConflict;
    logic coreMiss;
    logic setFull;
    logic allTx;
  } dpStat_t;

endpackage

// File: rtl/tcache_ctrl.sv
module tcache_ctrl
  import tcache_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] coreOpRaw,
  input  dpStat_t    stat,
  output ctrlStrb_t  strb,
  output logic       inTx,
  output logic [2:0] abortReason
);

  coreOp_e   op;
  abortRsn_e reasonQ;
  abortRsn_e abortCode;
  logic      abortReq;

  assign op = coreOp_e'(coreOpRaw);

  // Abort decision: snoop conflict first, then the core's own operation.
  always_comb begin
    abortReq  = 1'b0;
    abortCode = RSN_NONE;
    if (inTx) begin
      if (stat.snpConflict) begin
        abortReq  = 1'b1;
        abortCode = RSN_CONFLICT;
      end else begin
        case (op)
          OP_ABORT: begin
            abortReq  = 1'b1;
            abortCode = RSN_EXPLICIT;
          end
          OP_IO: begin
            abortReq  = 1'b1;
            abortCode = RSN_IO;
          end
          OP_LOAD, OP_STORE: begin
            if (stat.coreMiss && stat.setFull) begin
              abortReq  = 1'b1;
              abortCode = stat.allTx ? RSN_CAPACITY : RSN_ASSOC;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strb.doLoad    = (op == OP_LOAD)  && !abortReq;
    strb.doStore   = (op == OP_STORE) && !abortReq;
    strb.txMark    = inTx;
    strb.commitAll = inTx && (op == OP_COMMIT) && !abortReq;
    strb.abortAll  = abortReq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inTx    <= 1'b0;
      reasonQ <= RSN_NONE;
    end else if (!inTx && op == OP_BEGIN) begin
      inTx    <= 1'b1;
      reasonQ <= RSN_NONE;
    end else if (abortReq) begin
      inTx    <= 1'b0;
      reasonQ <= abortCode;
    end else if (strb.commitAll) begin
      inTx    <= 1'b0;
    end
  end

  assign abortReason = reasonQ;

endmodule

// File: rtl/tcache_dp.sv
module tcache_dp
  import tcache_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWData,
  input  logic [DATA_W-1:0] fillData,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  input  ctrlStrb_t         strb,
  output dpStat_t           stat,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData,
  output logic              snpRespValid,
  output logic              snpRespHit,
  output logic              snpRespDirty,
  output logic [DATA_W-1:0] snpRespData
);

  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;

  logic [NUM_WAYS-1:0] lineValid [NUM_SETS];
  logic [NUM_WAYS-1:0] rdSet     [NUM_SETS];
  logic [NUM_WAYS-1:0] wrSet     [NUM_SETS];
  logic [NUM_WAYS-1:0] lineDirty [NUM_SETS];
  logic [TAG_W-1:0]    lineTag   [NUM_SETS][NUM_WAYS];
  logic [DATA_W-1:0]   lineData  [NUM_SETS][NUM_WAYS];

  logic [IDX_W-1:0] coreIdx, snpIdx;
  logic [TAG_W-1:0] coreTag, snpTag;

  assign coreIdx = coreAddr[IDX_W-1:0];
  assign coreTag = coreAddr[ADDR_W-1:IDX_W];
  assign snpIdx  = snpAddr[IDX_W-1:0];
  assign snpTag  = snpAddr[ADDR_W-1:IDX_W];

  logic [NUM_WAYS-1:0] snpHitVec, killVec, coreValid, coreTxVec, coreHitVec;
  logic [WAY_W-1:0]    snpWay, hitWay, invWay, ntWay, tgtWay;
  logic                snpConflict, snpAnyHit, coreHit, invAny, ntAny, allTx;

  // snoop lookup against the current sets
  always_comb begin
    snpHitVec = '0;
    snpWay    = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (snpValid && lineValid[snpIdx][w] && lineTag[snpIdx][w] == snpTag) begin
        snpHitVec[w] = 1'b1;
        snpWay       = WAY_W'(w);
      end
    end
    snpAnyHit   = |snpHitVec;
    snpConflict = |(snpHitVec & (snpWrite ? (rdSet[snpIdx] | wrSet[snpIdx])
                                          : wrSet[snpIdx]));
    killVec     = (snpValid && snpWrite) ? snpHitVec : '0;
  end

  // core lookup sees the cache after this cycle's snoop invalidation
  always_comb begin
    coreValid  = lineValid[coreIdx] & ~((snpIdx == coreIdx) ? killVec : '0);
    coreTxVec  = rdSet[coreIdx] | wrSet[coreIdx];
    coreHitVec = '0;
    hitWay     = '0;
    invAny     = 1'b0;
    invWay     = '0;
    ntAny      = 1'b0;
    ntWay      = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (coreValid[w] && lineTag[coreIdx][w] == coreTag) begin
        coreHitVec[w] = 1'b1;
        hitWay        = WAY_W'(w);
      end
      if (!coreValid[w]) begin
        invAny = 1'b1;
        invWay = WAY_W'(w);
      end
      if (!coreTxVec[w]) begin
        ntAny = 1'b1;
        ntWay = WAY_W'(w);
      end
    end
    coreHit = |coreHitVec;
    if (coreHit)     tgtWay = hitWay;
    else if (invAny) tgtWay = invWay;
    else             tgtWay = ntWay;
  end

  // every line of the cache belongs to the transaction
  always_comb begin
    allTx = 1'b1;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (~&(rdSet[s] | wrSet[s])) allTx = 1'b0;
    end
  end

  always_comb begin
    stat.snpConflict = snpConflict;
    stat.coreMiss    = !coreHit;
    stat.setFull     = !(invAny || ntAny);
    stat.allTx       = allTx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        lineValid[s] <= '0;
        rdSet[s]     <= '0;
        wrSet[s]     <= '0;
        lineDirty[s] <= '0;
      end
      loadValid    <= 1'b0;
      snpRespValid <= 1'b0;
      snpRespHit   <= 1'b0;
      snpRespDirty <= 1'b0;
    end else begin
      loadValid    <= strb.doLoad;
      snpRespValid <= snpValid;
      snpRespHit   <= snpAnyHit && !snpConflict;
      snpRespDirty <= snpAnyHit && !snpConflict && lineDirty[snpIdx][snpWay];
      snpRespData  <= lineData[snpIdx][snpWay];

      // remote ownership request removes the local copy
      if (snpValid && snpWrite) begin
        lineValid[snpIdx] <= lineValid[snpIdx] & ~killVec;
        rdSet[snpIdx]     <= rdSet[snpIdx] & ~killVec;
        wrSet[snpIdx]     <= wrSet[snpIdx] & ~killVec;
        lineDirty[snpIdx] <= lineDirty[snpIdx] & ~killVec;
      end

      if (strb.abortAll) begin
        for (int s = 0; s < NUM_SETS; s++) begin
          lineValid[s] <= lineValid[s] & ~wrSet[s] &
                          ((s == int'(snpIdx)) ? ~killVec : '1);
          rdSet[s]     <= '0;
          wrSet[s]     <= '0;
        end
      end

      if (strb.commitAll) begin
        for (int s = 0; s < NUM_SETS; s++) begin
          lineDirty[s] <= lineDirty[s] | wrSet[s];
          rdSet[s]     <= '0;
          wrSet[s]     <= '0;
        end
      end

      if (strb.doLoad || strb.doStore) begin
        if (!coreHit) begin
          lineValid[coreIdx][tgtWay] <= 1'b1;
          lineTag[coreIdx][tgtWay]   <= coreTag;
          lineData[coreIdx][tgtWay]  <= strb.doStore ? coreWData : fillData;
          lineDirty[coreIdx][tgtWay] <= strb.doStore && !strb.txMark;
          rdSet[coreIdx][tgtWay]     <= strb.doLoad && strb.txMark;
          wrSet[coreIdx][tgtWay]     <= strb.doStore && strb.txMark;
        end else begin
          if (strb.doLoad && strb.txMark)  rdSet[coreIdx][tgtWay] <= 1'b1;
          if (strb.doStore) begin
            lineData[coreIdx][tgtWay] <= coreWData;
            if (strb.txMark) wrSet[coreIdx][tgtWay]     <= 1'b1;
            else             lineDirty[coreIdx][tgtWay] <= 1'b1;
          end
        end
        if (strb.doLoad) loadData <= coreHit ? lineData[coreIdx][hitWay] : fillData;
      end
    end
  end

endmodule

// File: rtl/tcache_top.sv
module tcache_top
  import tcache_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        coreOp,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWData,
  input  logic [DATA_W-1:0] fillData,
  input  logic              snpValid,
  input  logic              snpWrite,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData,
  output logic              snpRespValid,
  output logic              snpRespHit,
  output logic              snpRespDirty,
  output logic [DATA_W-1:0] snpRespData,
  output logic              inTx,
  output logic [2:0]        abortReason
);

  ctrlStrb_t strb;
  dpStat_t   stat;

  tcache_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .coreOpRaw   (coreOp),
    .stat        (stat),
    .strb        (strb),
    .inTx        (inTx),
    .abortReason (abortReason)
  );

  tcache_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .coreAddr     (coreAddr),
    .coreWData    (coreWData),
    .fillData     (fillData),
    .snpValid     (snpValid),
    .snpWrite     (snpWrite),
    .snpAddr      (snpAddr),
    .strb         (strb),
    .stat         (stat),
    .loadValid    (loadValid),
    .loadData     (loadData),
    .snpRespValid (snpRespValid),
    .snpRespHit   (snpRespHit),
    .snpRespDirty (snpRespDirty),
    .snpRespData  (snpRespData)
  );

endmodule

// File: rtl/tcache_chk.sv
module tcache_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] coreOp,
  input logic       snpValid,
  input logic       loadValid,
  input logic       snpRespValid,
  input logic       inTx,
  input logic [2:0] abortReason
);

  a_r1_reason_legal: assert property (@(posedge clk) disable iff (rst)
    abortReason <= 3'd5);

  a_r2_load_answers: assert property (@(posedge clk) disable iff (rst)
    (!inTx && coreOp == 3'd1) |=> loadValid);

  a_r6_commit_clean: assert property (@(posedge clk) disable iff (rst)
    (inTx && coreOp == 3'd4 && !snpValid) |=> (!inTx && abortReason == 3'd0));

  a_r10_io_abort: assert property (@(posedge clk) disable iff (rst)
    (inTx && coreOp == 3'd6 && !snpValid) |=> (!inTx && abortReason == 3'd4));

  a_r11_explicit_abort: assert property (@(posedge clk) disable iff (rst)
    (inTx && coreOp == 3'd5 && !snpValid) |=> (!inTx && abortReason == 3'd5));

  a_r12_reason_held: assert property (@(posedge clk) disable iff (rst)
    (!inTx && coreOp != 3'd3) |=> $stable(abortReason));

  a_r12_begin_clears: assert property (@(posedge clk) disable iff (rst)
    (!inTx && coreOp == 3'd3) |=> (inTx && abortReason == 3'd0));

  a_r13_snoop_answered: assert property (@(posedge clk) disable iff (rst)
    snpValid |=> snpRespValid);

endmodule

bind tcache_top tcache_chk u_chk (.*);

// File: tb/tcache_top_bench.sv
module tcache_top_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] coreOp = 3'd0;
  logic [7:0] coreAddr = '0, coreWData = '0, fillData = '0, snpAddr = '0;
  logic       snpValid = 1'b0, snpWrite = 1'b0;
  logic       loadValid, snpRespValid, snpRespHit, snpRespDirty, inTx;
  logic [7:0] loadData, snpRespData;
  logic [2:0] abortReason;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [2:0] NOP = 3'd0, LD = 3'd1, ST = 3'd2, BEG = 3'd3,
                         CMT = 3'd4, ABT = 3'd5, IOP = 3'd6;

  always #5 clk = ~clk;

  tcache_top #(.ADDR_W(8), .DATA_W(8), .NUM_SETS(4), .NUM_WAYS(2)) u_tcache_top (
    .clk(clk), .rst(rst), .coreOp(coreOp), .coreAddr(coreAddr),
    .coreWData(coreWData), .fillData(fillData), .snpValid(snpValid),
    .snpWrite(snpWrite), .snpAddr(snpAddr), .loadValid(loadValid),
    .loadData(loadData), .snpRespValid(snpRespValid), .snpRespHit(snpRespHit),
    .snpRespDirty(snpRespDirty), .snpRespData(snpRespData), .inTx(inTx),
    .abortReason(abortReason)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, sample 1 ns after the rising edge
  task automatic step(input logic [2:0] op, input logic [7:0] a,
                      input logic [7:0] wd, input logic [7:0] fd,
                      input logic sv, input logic sw, input logic [7:0] sa);
    @(negedge clk);
    coreOp = op; coreAddr = a; coreWData = wd; fillData = fd;
    snpValid = sv; snpWrite = sw; snpAddr = sa;
    @(posedge clk);
    #1;
  endtask

  task automatic op1(input logic [2:0] op, input logic [7:0] a,
                     input logic [7:0] wd, input logic [7:0] fd);
    step(op, a, wd, fd, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic snoop(input logic sw, input logic [7:0] sa);
    step(NOP, 8'h00, 8'h00, 8'h00, 1'b1, sw, sa);
  endtask

  task automatic doReset;
    @(negedge clk);
    rst = 1'b1; coreOp = NOP; snpValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [7:0] mkAddr(input int tag, input int idx);
    return {tag[5:0], idx[1:0]};
  endfunction

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset();
    #1;
    check("R1", "inTx", inTx, 0);
    check("R1", "reason", abortReason, 0);
    check("R1", "loadValid", loadValid, 0);
    check("R1", "snpRespValid", snpRespValid, 0);
    snoop(1'b0, 8'h09);
    check("R1", "snoop hit on empty cache", snpRespHit, 0);

    // R2 non-transactional miss, hit, store
    op1(LD, 8'h09, 8'h00, 8'h12);
    check("R2", "miss valid", loadValid, 1);
    check("R2", "miss data", loadData, 8'h12);
    op1(LD, 8'h09, 8'h00, 8'h34);
    check("R2", "hit data", loadData, 8'h12);
    op1(ST, 8'h09, 8'h56, 8'h00);
    op1(LD, 8'h09, 8'h00, 8'h00);
    check("R2", "store then load", loadData, 8'h56);
    // fill every line of the cache, then read all back
    doReset();
    for (int t = 1; t <= 2; t++)
      for (int i = 0; i < 4; i++)
        op1(ST, mkAddr(t, i), mkAddr(t, i) ^ 8'h5C, 8'h00);
    for (int t = 1; t <= 2; t++)
      for (int i = 0; i < 4; i++) begin
        op1(LD, mkAddr(t, i), 8'h00, 8'hEE);
        check("R2", $sformatf("sweep load %0h", mkAddr(t, i)), loadData, mkAddr(t, i) ^ 8'h5C);
      end

    // R4 conflict rule, R6 speculative data hidden
    for (int lw = 0; lw < 2; lw++)
      for (int sw = 0; sw < 2; sw++) begin
        doReset();
        op1(BEG, 8'h00, 8'h00, 8'h00);
        op1(lw ? ST : LD, 8'h09, 8'h3C, 8'h11);
        snoop(sw[0], 8'h09);
        check("R4", $sformatf("reason lw=%0d sw=%0d", lw, sw), abortReason,
              (lw == 1 || sw == 1) ? 1 : 0);
        check("R4", $sformatf("inTx lw=%0d sw=%0d", lw, sw), inTx,
              (lw == 1 || sw == 1) ? 0 : 1);
        if (lw == 1 && sw == 0) check("R6", "speculative line hidden", snpRespHit, 0);
        if (lw == 0 && sw == 0) begin
          check("R4", "read-set line shared hit", snpRespHit, 1);
          check("R4", "read-set line shared data", snpRespData, 8'h11);
        end
      end

    // R5 snoops outside the sets
    doReset();
    op1(BEG, 8'h00, 8'h00, 8'h00);
    op1(ST, 8'h09, 8'h21, 8'h00);
    snoop(1'b1, 8'h0D);
    check("R5", "snoop write other tag reason", abortReason, 0);
    check("R5", "snoop write other tag inTx", inTx, 1);
    snoop(1'b0, 8'h22);
    check("R5", "snoop read uncached inTx", inTx, 1);

    // R6 commit publishes, dirty reported
    doReset();
    op1(LD, 8'h22, 8'h00, 8'h07);
    op1(BEG, 8'h00, 8'h00, 8'h00);
    op1(ST, 8'h09, 8'h5A, 8'h00);
    op1(CMT, 8'h00, 8'h00, 8'h00);
    check("R6", "commit inTx", inTx, 0);
    check("R6", "commit reason", abortReason, 0);
    snoop(1'b0, 8'h09);
    check("R6", "published hit", snpRespHit, 1);
    check("R6", "published data", snpRespData, 8'h5A);
    check("R6", "published dirty", snpRespDirty, 1);
    snoop(1'b0, 8'h22);
    check("R6", "clean line not dirty", snpRespDirty, 0);

    // R3 own speculative data, R7 abort effects
    doReset();
    op1(ST, 8'h09, 8'h11, 8'h00);
    op1(BEG, 8'h00, 8'h00, 8'h00);
    op1(ST, 8'h09, 8'h22, 8'h00);
    op1(LD, 8'h09, 8'h00, 8'h33);
    check("R3", "own speculative data", loadData, 8'h22);
    op1(LD, 8'h16, 8'h00, 8'h44);
    check("R3", "tx load miss data", loadData, 8'h44);
    check("R3", "still in tx", inTx, 1);
    op1(ABT, 8'h00, 8'h00, 8'h00);
    check("R11", "explicit abort reason", abortReason, 5);
    op1(LD, 8'h09, 8'h00, 8'h99);
    check("R7", "write-set line dropped", loadData, 8'h99);
    op1(BEG, 8'h00, 8'h00, 8'h00);
    snoop(1'b1, 8'h16);
    check("R7", "old read set cleared reason", abortReason, 0);
    check("R7", "old read set cleared inTx", inTx, 1);

    // R8 associativity overflow
    doReset();
    op1(BEG, 8'h00, 8'h00, 8'h00);
    op1(LD, mkAddr(1, 0), 8'h00, 8'h01);
    op1(LD, mkAddr(2, 0), 8'h00, 8'h02);
    check("R8", "set full no abort yet", abortReason, 0);
    op1(LD, mkAddr(3, 0), 8'h00, 8'h03);
    check("R8", "assoc reason", abortReason, 3);
    check("R8", "assoc inTx", inTx, 0);

    // R9 capacity overflow
    doReset();
    op1(BEG, 8'h00, 8'h00, 8'h00);
    for (int t = 1; t <= 2; t++)
      for (int i = 0; i < 4; i++)
        op1((i % 2 == 0) ? LD : ST, mkAddr(t, i), 8'h0F, 8'h01);
    check("R9", "whole cache in tx reason", abortReason, 0);
    check("R9", "whole cache in tx inTx", inTx, 1);
    op1(LD, mkAddr(3, 2), 8'h00, 8'h00);
    check("R9", "capacity reason", abortReason, 2);

    // R10, R11, R12 opcodes and reason holding
    doReset();
    op1(IOP, 8'h00, 8'h00, 8'h00);
    check("R10", "io outside tx reason", abortReason, 0);
    check("R10", "io outside tx inTx", inTx, 0);
    op1(CMT, 8'h00, 8'h00, 8'h00);
    op1(ABT, 8'h00, 8'h00, 8'h00);
    check("R11", "commit/abort outside tx", {inTx, abortReason}, 0);
    op1(BEG, 8'h00, 8'h00, 8'h00);
    op1(IOP, 8'h00, 8'h00, 8'h00);
    check("R10", "io in tx reason", abortReason, 4);
    check("R10", "io in tx inTx", inTx, 0);
    op1(CMT, 8'h00, 8'h00, 8'h00);
    op1(LD, 8'h05, 8'h00, 8'h00);
    check("R12", "reason held", abortReason, 4);
    op1(BEG, 8'h00, 8'h00, 8'h00);
    check("R12", "begin clears reason", abortReason, 0);
    check("R12", "begin enters tx", inTx, 1);

    // R13 same-cycle snoop conflict against commit and load
    doReset();
    op1(BEG, 8'h00, 8'h00, 8'h00);
    op1(ST, 8'h09, 8'h44, 8'h00);
    step(CMT, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 8'h09);
    check("R13", "conflict beats commit reason", abortReason, 1);
    check("R13", "conflict beats commit inTx", inTx, 0);
    op1(LD, 8'h09, 8'h00, 8'h66);
    check("R13", "commit not published", loadData, 8'h66);
    op1(BEG, 8'h00, 8'h00, 8'h00);
    op1(ST, 8'h09, 8'h45, 8'h00);
    step(CMT, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 8'h0D);
    check("R13", "unrelated snoop commit reason", abortReason, 0);
    snoop(1'b0, 8'h09);
    check("R13", "unrelated snoop commit data", snpRespData, 8'h45);
    op1(BEG, 8'h00, 8'h00, 8'h00);
    op1(ST, 8'h09, 8'h01, 8'h00);
    step(LD, 8'h16, 8'h00, 8'h00, 1'b1, 1'b0, 8'h09);
    check("R13", "load dropped on conflict", loadValid, 0);
    check("R13", "load cycle conflict reason", abortReason, 1);

    op1(NOP, 8'h00, 8'h00, 8'h00);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule